// File: doc/BRIEF.md
# Pipelined Dual-Basis Multiplier over GF(2^m)

This block multiplies two elements of the binary extension field GF(2^M). The first operand arrives as its dual-basis coordinates, the second as ordinary polynomial-basis coefficients, and the product leaves in dual-basis coordinates. Algebraic decoders and elliptic-curve datapaths use it where products are consumed as trace-form coordinates. The reduction polynomial is fixed at elaboration time. A parameter selects a trinomial x^M + x^N + 1 or a pentanomial x^M + x^(K+2) + x^(K+1) + x^K + 1.

The datapath is a chain of M identical systolic rows, and data moves forward only. Row i forms the inner product of the current dual-coefficient window with B, which gives product bit i. It then slides the window one place along and appends the next coefficient, computed with the field's linear recurrence. A new operand pair can enter on every clock. A valid flag moves through the chain beside the data, so the result is flagged exactly M edges later. The default field is GF(2^8) with x^8 + x^4 + x^3 + x^2 + 1 (pentanomial, K = 2).

Top module: `gfdual_mul`

## Requirements
- R1: With the default field, `product` equals the dual-basis coordinates of A·B. Coordinate i of an element Y is Tr(α^i·Y), where α is a root of the field polynomial and Tr is the absolute trace.
- R2: Bit j of `bPoly` is the coefficient of α^j. Bit i of `aDual` and bit i of `product` are dual coordinate i.
- R3: An operand pair sampled at a rising edge with `inValid` high appears on `product` with `prodValid` high right after the M-th rising edge, counting the sampling edge as the first.
- R4: Operand pairs presented on consecutive cycles are all accepted, and each yields its own result on consecutive cycles.
- R5: `prodValid` follows the pattern of `inValid` delayed by M edges, including gaps.
- R6: Operands presented while `inValid` is low are ignored. While `prodValid` is low, `product` keeps the last valid result, or zero after reset.
- R7: If either operand is zero, the product is zero.
- R8: When `bPoly` is 1 (only bit 0 set), `product` equals `aDual`.
- R9: A synchronous `rst` clears `prodValid` and `product` to zero at the next edge and discards every pair in flight.
- R10: Selecting the trinomial form (for example M = 7, x^7 + x + 1) gives correct dual-basis products for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair present this cycle |
| aDual | input | M | Operand A, dual-basis coordinates |
| bPoly | input | M | Operand B, polynomial-basis coefficients |
| prodValid | output | 1 | Product valid |
| product | output | M | A·B, dual-basis coordinates |

## Verification
The hardest conditions to reach from the ports are pipelines that are full but broken by gaps, and a reset that arrives while every stage holds a different pair. Either one would expose a stage that captures stale data or a valid flag that slips one stage. The stimulus fills the array back to back with seeded random pairs, then thins the issue rate at random so gaps fall at every depth, and then asserts reset mid-stream. Expected values come from an independent trace-based model. That model maps a random polynomial-basis element into dual coordinates, multiplies modulo the field polynomial, and maps the product back.

// File: rtl/gfdual_pkg.sv
package gfdual_pkg;

  // Shape of the field polynomial, fixed at elaboration.
  typedef enum logic {
    POLY_TRI   = 1'b0,
    POLY_PENTA = 1'b1
  } polyKind_e;

  // Per-stage strobes from control to datapath.
  typedef struct packed {
    logic clear;
    logic capture;
  } stageStrobe_t;

endpackage

// File: rtl/gfdual_inner.sv
module gfdual_inner #(
  parameter int M = 8
) (
  input  logic [M-1:0] window,
  input  logic [M-1:0] bOp,
  output logic         innerBit
);

  // GF(2) inner product: AND terms followed by an XOR tree.
  always_comb innerBit = ^(window & bOp);

endmodule

// File: rtl/gfdual_row.sv
module gfdual_row
  import gfdual_pkg::*;
#(
  parameter int        M    = 8,
  parameter polyKind_e KIND = POLY_PENTA,
  parameter int        N    = 1,
  parameter int        K    = 2
) (
  input  logic [M-1:0] window,
  input  logic [M-1:0] bOp,
  output logic         innerBit,
  output logic [M-1:0] windowNext
);

  logic feedback;

  gfdual_inner #(.M(M)) uInner (
    .window  (window),
    .bOp     (bOp),
    .innerBit(innerBit)
  );

  // Next dual coefficient from the recurrence set by the field polynomial.
  if (KIND == POLY_TRI) begin : gTri
    always_comb feedback = window[0] ^ window[N];
  end else begin : gPenta
    always_comb feedback = window[0] ^ window[K] ^ window[K+1] ^ window[K+2];
  end

  // Slide the window by one coefficient.
  always_comb windowNext = {feedback, window[M-1:1]};

endmodule

// File: rtl/gfdual_ctrl.sv
module gfdual_ctrl
  import gfdual_pkg::*;
#(
  parameter int M = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output stageStrobe_t [M-1:0]     strb,
  output logic                     prodValid
);

  logic [M-1:0] occupied;

  always_ff @(posedge clk) begin
    if (rst) occupied <= '0;
    else     occupied <= {occupied[M-2:0], inValid};
  end

  for (genvar i = 0; i < M; i++) begin : gStrb
    if (i == 0) begin : gHead
      always_comb strb[i].capture = inValid & ~rst;
    end else begin : gBody
      always_comb strb[i].capture = occupied[i-1] & ~rst;
    end
    always_comb strb[i].clear = rst;
  end

  always_comb prodValid = occupied[M-1];

endmodule

// File: rtl/gfdual_datapath.sv
module gfdual_datapath
  import gfdual_pkg::*;
#(
  parameter int        M    = 8,
  parameter polyKind_e KIND = POLY_PENTA,
  parameter int        N    = 1,
  parameter int        K    = 2
) (
  input  logic                 clk,
  input  stageStrobe_t [M-1:0] strb,
  input  logic [M-1:0]         aDual,
  input  logic [M-1:0]         bPoly,
  output logic [M-1:0]         product
);

  localparam int LastStage = M - 1;

  for (genvar i = 0; i < M; i++) begin : gStage
    logic [M-1:0] winIn;
    logic [M-1:0] bIn;
    logic [M-1:0] cIn;
    logic         innerBit;
    logic [M-1:0] cQ;

    if (i == 0) begin : gSrc
      always_comb begin
        winIn = aDual;
        bIn   = bPoly;
        cIn   = '0;
      end
    end else begin : gSrc
      always_comb begin
        winIn = gStage[i-1].gCell.winQ;
        bIn   = gStage[i-1].gCell.bQ;
        cIn   = gStage[i-1].cQ;
      end
    end

    if (i < LastStage) begin : gCell
      logic [M-1:0] winNext;
      logic [M-1:0] winQ;
      logic [M-1:0] bQ;

      gfdual_row #(.M(M), .KIND(KIND), .N(N), .K(K)) uRow (
        .window    (winIn),
        .bOp       (bIn),
        .innerBit  (innerBit),
        .windowNext(winNext)
      );

      always_ff @(posedge clk) begin
        if (strb[i].clear) begin
          winQ <= '0;
          bQ   <= '0;
          cQ   <= '0;
        end else if (strb[i].capture) begin
          winQ <= winNext;
          bQ   <= bIn;
          cQ   <= cIn | ({{(M-1){1'b0}}, innerBit} << i);
        end
      end
    end else begin : gTail
      gfdual_inner #(.M(M)) uInner (
        .window  (winIn),
        .bOp     (bIn),
        .innerBit(innerBit)
      );

      always_ff @(posedge clk) begin
        if (strb[i].clear)        cQ <= '0;
        else if (strb[i].capture) cQ <= cIn | ({{(M-1){1'b0}}, innerBit} << i);
      end
    end
  end

  always_comb product = gStage[LastStage].cQ;

endmodule

// File: rtl/gfdual_mul.sv
module gfdual_mul
  import gfdual_pkg::*;
#(
  parameter int        M    = 8,
  parameter polyKind_e KIND = POLY_PENTA,
  parameter int        N    = 1,
  parameter int        K    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [M-1:0] aDual,
  input  logic [M-1:0] bPoly,
  output logic         prodValid,
  output logic [M-1:0] product
);

  if (M < 3) begin : gBadWidth
    $error("gfdual_mul: M must be at least 3");
  end
  if (KIND == POLY_TRI && (N < 1 || N >= M)) begin : gBadTri
    $error("gfdual_mul: trinomial middle exponent out of range");
  end
  if (KIND == POLY_PENTA && (K < 1 || K + 2 >= M)) begin : gBadPenta
    $error("gfdual_mul: pentanomial exponent out of range");
  end

  stageStrobe_t [M-1:0] strb;

  gfdual_ctrl #(.M(M)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strb     (strb),
    .prodValid(prodValid)
  );

  gfdual_datapath #(.M(M), .KIND(KIND), .N(N), .K(K)) uDp (
    .clk    (clk),
    .strb   (strb),
    .aDual  (aDual),
    .bPoly  (bPoly),
    .product(product)
  );

endmodule

// File: rtl/gfdual_mul_chk.sv
module gfdual_mul_chk #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [M-1:0] aDual,
  input logic [M-1:0] bPoly,
  input logic         prodValid,
  input logic [M-1:0] product
);

  logic [M-1:0] vldLine;
  logic [M-1:0] zeroLine;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldLine  <= '0;
      zeroLine <= '0;
    end else begin
      vldLine  <= {vldLine[M-2:0], inValid};
      zeroLine <= {zeroLine[M-2:0], (aDual == '0) || (bPoly == '0)};
    end
  end

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!prodValid && product == '0));

  // R3
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    prodValid == vldLine[M-1]);

  // R6
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !prodValid |-> $stable(product));

  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (prodValid && zeroLine[M-1]) |-> product == '0);

endmodule

bind gfdual_mul gfdual_mul_chk #(.M(M)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .aDual    (aDual),
  .bPoly    (bPoly),
  .prodValid(prodValid),
  .product  (product)
);

// File: tb/tb_gfdual_mul.sv
`timescale 1ns/1ps
module tb_gfdual_mul;
  import gfdual_pkg::*;

  localparam int       MP = 8;
  localparam int       MT = 7;
  localparam bit [8:0] PP = 9'h11D;  // x^8+x^4+x^3+x^2+1
  localparam bit [8:0] PT = 9'h083;  // x^7+x+1

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [MP-1:0] aP = '0, bP = '0, prodP;
  logic [MT-1:0] aT = '0, bT = '0, prodT;
  logic vldP, vldT;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gfdual_mul #(.M(MP), .KIND(POLY_PENTA), .N(1), .K(2)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .aDual(aP), .bPoly(bP),
    .prodValid(vldP), .product(prodP));

  gfdual_mul #(.M(MT), .KIND(POLY_TRI), .N(1), .K(1)) dutTri (
    .clk(clk), .rst(rst), .inValid(inValid), .aDual(aT), .bPoly(bT),
    .prodValid(vldT), .product(prodT));

  // Expected-result pipelines, one slot per edge of latency.
  bit         qvP [MP];
  logic [7:0] qdP [MP];
  string      qtP [MP];
  bit         qvT [MT];
  logic [7:0] qdT [MT];
  logic [7:0] lastP = '0, lastT = '0;

  function automatic logic [7:0] gfMul(input logic [7:0] x, input logic [7:0] y,
                                       input int m, input bit [8:0] p);
    logic [8:0] xx = {1'b0, x};
    logic [8:0] r  = '0;
    for (int i = 0; i < m; i++) begin
      if (y[i]) r = r ^ xx;
      xx = xx << 1;
      if (xx[m]) xx = xx ^ p;
    end
    return r[7:0];
  endfunction

  function automatic bit trace(input logic [7:0] y, input int m, input bit [8:0] p);
    logic [7:0] t = y;
    logic [7:0] s = y;
    for (int i = 1; i < m; i++) begin
      t = gfMul(t, t, m, p);
      s = s ^ t;
    end
    return s[0];
  endfunction

  function automatic logic [7:0] toDual(input logic [7:0] x, input int m, input bit [8:0] p);
    logic [7:0] ap = 8'd1;
    logic [7:0] d  = '0;
    for (int i = 0; i < m; i++) begin
      d[i] = trace(gfMul(ap, x, m, p), m, p);
      ap   = gfMul(ap, 8'd2, m, p);
    end
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    if (qvP[MP-1]) begin
      check(vldP === 1'b1 && prodP === qdP[MP-1], qtP[MP-1], {7'd0, vldP} << 7 | prodP, qdP[MP-1]);
      lastP = qdP[MP-1];
    end else begin
      check(vldP === 1'b0 && prodP === lastP, "R6 hold/R5 gap", prodP, lastP);
    end
    if (qvT[MT-1]) begin
      check(vldT === 1'b1 && {1'b0, prodT} === qdT[MT-1], "R10 trinomial", {1'b0, prodT}, qdT[MT-1]);
      lastT = qdT[MT-1];
    end else begin
      check(vldT === 1'b0 && {1'b0, prodT} === lastT, "R10 trinomial hold", {1'b0, prodT}, lastT);
    end
  endtask

  // One cycle: check, advance model, drive the next pair (x in polynomial basis).
  task automatic cycle(input bit v, input logic [7:0] x, input logic [7:0] b, input string tag);
    logic [7:0] ap, ep, at, et;
    @(negedge clk);
    checkOutputs();
    for (int i = MP - 1; i > 0; i--) begin
      qvP[i] = qvP[i-1]; qdP[i] = qdP[i-1]; qtP[i] = qtP[i-1];
    end
    for (int i = MT - 1; i > 0; i--) begin
      qvT[i] = qvT[i-1]; qdT[i] = qdT[i-1];
    end
    ap = toDual(x, MP, PP);
    ep = toDual(gfMul(x, b, MP, PP), MP, PP);
    at = toDual(x & 8'h7F, MT, PT);
    et = toDual(gfMul(x & 8'h7F, b & 8'h7F, MT, PT), MT, PT);
    if (tag == "R7") begin ep = '0; et = '0; end
    if (tag == "R8") begin ep = ap; et = at; end
    qvP[0] = v; qdP[0] = ep; qtP[0] = tag;
    qvT[0] = v; qdT[0] = et;
    inValid = v;
    aP = v ? ap : 8'($urandom);
    bP = v ? b  : 8'($urandom);
    aT = v ? at[MT-1:0] : 7'($urandom);
    bT = v ? b[MT-1:0]  : 7'($urandom);
  endtask

  task automatic applyReset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    for (int i = 0; i < MP; i++) qvP[i] = 1'b0;
    for (int i = 0; i < MT; i++) qvT[i] = 1'b0;
    lastP = '0;
    lastT = '0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(vldP === 1'b0 && prodP === '0, "R9 reset", prodP, 8'h00);
      check(vldT === 1'b0 && prodT === '0, "R9 reset", {1'b0, prodT}, 8'h00);
    end
    rst = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MP; i++) begin qvP[i] = 1'b0; qdP[i] = '0; qtP[i] = ""; end
    for (int i = 0; i < MT; i++) begin qvT[i] = 1'b0; qdT[i] = '0; end

    applyReset(4);

    // Directed corners
    cycle(1, 8'h00, 8'($urandom), "R7");
    cycle(1, 8'($urandom), 8'h00, "R7");
    cycle(1, 8'h5A, 8'h01, "R8");
    cycle(1, 8'hC3, 8'h01, "R8");
    cycle(1, 8'h01, 8'h01, "R1 one*one");
    cycle(1, 8'hFF, 8'hFF, "R1 all ones");
    cycle(1, 8'h37, 8'h02, "R2 times alpha");
    cycle(1, 8'h91, 8'h80, "R2 top coefficient");
    for (int i = 0; i < MP + 2; i++) cycle(0, 8'h00, 8'h00, "R6");

    // Isolated pair: result flagged exactly M edges later
    cycle(1, 8'hA7, 8'h4D, "R3 latency");
    for (int i = 0; i < MP + 2; i++) cycle(0, 8'h00, 8'h00, "R6");

    // Back to back
    for (int i = 0; i < 400; i++) cycle(1, 8'($urandom), 8'($urandom), "R4 back-to-back R1");

    // Random gaps
    for (int i = 0; i < 400; i++)
      cycle(($urandom % 4) != 0, 8'($urandom), 8'($urandom), "R5 with gaps");

    // Reset with a full pipeline
    for (int i = 0; i < MP; i++) cycle(1, 8'($urandom), 8'($urandom), "R1");
    applyReset(3);
    for (int i = 0; i < 40; i++) cycle(1, 8'($urandom), 8'($urandom), "R9 after reset R1");
    for (int i = 0; i < MP + 2; i++) cycle(0, 8'h00, 8'h00, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule